// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

The block is a chain of 4-bit synchronous binary counter stages that all share one clock. Every stage can be zeroed, loaded in parallel from a data bus, or stepped by one, and each stage holds its value when it is not told to count. Counting needs two enables to be high at once. One enable, the parallel enable, goes to every stage unchanged. The other, the trickle enable, passes along the chain: each stage raises its carry only at its terminal count of 15 while its own trickle enable is high. That carry is the trickle enable of the next stage.

A parameter sets the number of stages. The chain therefore behaves as a single binary counter of 4 times that many bits, and its final carry can serve as the output of a frequency divider. With two stages the modulus is 256, so a 100 kHz clock gives a final carry rate of about 391 Hz. Zeroing and loading are synchronous and apply to the whole chain at once. The priority is reset, then clear, then load, then count, then hold.

Top module: `cascade_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the whole count becomes 0 on that edge. `rst` has priority over every other input.
- R2: While `rst` is low and `clr_n` is low at a rising edge, the count becomes 0. This holds whatever the values of `load_n`, `din` and the enables.
- R3: While `rst` is low, `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din`. The enables have no effect on this. Stage k takes `din[4k+3:4k]`.
- R4: With `rst` low, `clr_n` and `load_n` high, and both `en_p` and `en_t` high, the lowest stage goes up by one on each edge and wraps from 15 to 0.
- R5: With `rst` low and `clr_n` and `load_n` high, `q` holds its value whenever `en_p` or `en_t` is low.
- R6: Each stage's carry is high exactly when that stage reads 15 and its trickle enable is high. The carry does not depend on `en_p`. `carry_out` is the carry of the last stage, and it follows `q` in the same cycle with no register between them.
- R7: Stage k+1 steps only on edges where stage k carries and `en_p` is high. The full `q` therefore counts by one, modulo 2^(4*STAGES).
- R8: With two stages and both enables held high from a count of 0, `carry_out` is high for exactly one cycle in every 256.
- R9: While `en_t` is low, `carry_out` stays low even when every stage reads 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to zero |
| clr_n | input | 1 | Synchronous active-low clear to zero |
| load_n | input | 1 | Synchronous active-low parallel load |
| din | input | 4*STAGES | Parallel load data, lowest stage in the low bits |
| en_p | input | 1 | Parallel count enable, sent to every stage |
| en_t | input | 1 | Trickle count enable, passed along the carry chain |
| q | output | 4*STAGES | Registered count of the whole chain |
| carry_out | output | 1 | Carry of the last stage |

## Verification
A change on `rst`, `clr_n`, `load_n`, `din` or the enables shows up on `q` at the first rising edge after it. `carry_out` is combinational from `q` and `en_t`, so it is valid in the same cycle as the count it flags. The bench changes inputs just after a falling edge and keeps a bench-side model of the count, which it advances at each rising edge. It compares `q` and `carry_out` with that model at the next falling edge, so every result is checked exactly one register stage after its stimulus. Loads are checked for all 256 values, and the free-running sweeps cover several wraps of the full chain.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_ZERO  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cascade_tc_detect.sv
module cascade_tc_detect #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] value,
  input  logic          trickle,
  output logic          carry
);
  localparam logic [DW-1:0] TERMINAL = {DW{1'b1}};

  always_comb begin
    carry = trickle && (value == TERMINAL);
  end
endmodule

// File: rtl/cascade_stage.sv
module cascade_stage
  import cascade_counter_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic [DW-1:0] d,
  input  logic          en_p,
  input  logic          en_t,
  output logic [DW-1:0] q,
  output logic          carry
);
  cnt_op_e op;

  always_comb begin
    if (!clr_n)             op = OP_ZERO;
    else if (!load_n)       op = OP_LOAD;
    else if (en_p && en_t)  op = OP_STEP;
    else                    op = OP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_ZERO: q <= '0;
        OP_LOAD: q <= d;
        OP_STEP: q <= q + 1'b1;
        default: q <= q;
      endcase
    end
  end

  cascade_tc_detect #(.DW(DW)) u_tc (
    .value   (q),
    .trickle (en_t),
    .carry   (carry)
  );

  // R2: clear zeroes the stage on the next edge
  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (q == '0));

  // R3: load copies the data input
  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> (q == $past(d)));

  // R4: counting steps by one with wrap
  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_p && en_t) |=> (q == DW'($past(q) + 1'b1)));

  // R5: inhibit keeps the value
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));

  // R6: carry never rises without the trickle enable
  assert_carry_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !en_t |-> !carry);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGES = 2,
  parameter int DW     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_n,
  input  logic                 load_n,
  input  logic [STAGES*DW-1:0] din,
  input  logic                 en_p,
  input  logic                 en_t,
  output logic [STAGES*DW-1:0] q,
  output logic                 carry_out
);
  localparam int TOTAL_W = STAGES * DW;

  logic [STAGES:0] chain;

  assign chain[0] = en_t;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cascade_stage #(.DW(DW)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .clr_n  (clr_n),
      .load_n (load_n),
      .d      (din[k*DW +: DW]),
      .en_p   (en_p),
      .en_t   (chain[k]),
      .q      (q[k*DW +: DW]),
      .carry  (chain[k+1])
    );
  end

  assign carry_out = chain[STAGES];

  // R9: a low trickle enable blocks the final carry
  assert_final_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !en_t |-> !carry_out);

  // R7: the whole chain counts by one when enabled
  assert_chain_step_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_p && en_t) |=> (q == TOTAL_W'($past(q) + 1'b1)));

  // R1: reset zeroes the whole chain
  assert_reset_R1: assert property (@(posedge clk) disable iff (1'b0)
    $past(rst) |-> (q == '0));
endmodule

// File: tb/cascade_counter_test.sv
module cascade_counter_test;
  localparam int STAGES = 2;
  localparam int W = STAGES * 4;

  logic clk = 1'b0;
  logic rst, clr_n, load_n, en_p, en_t;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic carry_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [W-1:0] exp_q;

  always #5 clk = ~clk;

  cascade_counter #(.STAGES(STAGES), .DW(4)) uut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
    .din(din), .en_p(en_p), .en_t(en_t), .q(q), .carry_out(carry_out)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] cur);
    if (rst) return '0;
    if (!clr_n) return '0;
    if (!load_n) return din;
    if (en_p && en_t) return cur + 1'b1;
    return cur;
  endfunction

  function automatic int exp_carry();
    return (exp_q == {W{1'b1}} && en_t) ? 1 : 0;
  endfunction

  task automatic tick();
    @(posedge clk);
    exp_q = model(exp_q);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int pulses;
    int last_pulse;
    int gap_bad;
    rst = 1; clr_n = 1; load_n = 1; en_p = 1; en_t = 1; din = 8'hA5;
    exp_q = 'x;
    tick(); tick();
    check("R1 reset q", q, 0);
    check("R1 reset carry", carry_out, 0);

    // R4 R7 R6: free-running count over several wraps
    rst = 0;
    for (int i = 0; i < 600; i++) begin
      tick();
      check("R7 chain count", q, exp_q);
      check("R6 carry", carry_out, exp_carry());
    end

    // R3: load every value, with the enables both high and both low
    for (int v = 0; v < 256; v++) begin
      load_n = 0; din = v[W-1:0]; en_p = v[0]; en_t = v[1];
      tick();
      check("R3 load", q, v);
      check("R3 load exp", q, exp_q);
    end
    load_n = 1;

    // R5: hold with en_p low
    load_n = 0; din = 8'h3C; tick(); load_n = 1;
    en_p = 0; en_t = 1;
    for (int i = 0; i < 5; i++) begin tick(); check("R5 hold en_p", q, 8'h3C); end
    en_p = 1; en_t = 0;
    for (int i = 0; i < 5; i++) begin tick(); check("R5 hold en_t", q, 8'h3C); end

    // R9 and R6: carry at all ones
    load_n = 0; din = 8'hFF; tick(); load_n = 1;
    en_p = 1; en_t = 0; #1;
    check("R9 carry blocked", carry_out, 0);
    en_p = 0; en_t = 1; #1;
    check("R6 carry without en_p", carry_out, 1);
    tick();
    check("R5 hold at FF", q, 8'hFF);

    // R7: lower stage carries into upper stage
    load_n = 0; din = 8'h0E; tick(); load_n = 1;
    en_p = 1; en_t = 1;
    tick(); check("R4 step to 0F", q, 8'h0F);
    tick(); check("R7 carry into upper", q, 8'h10);
    // upper stage must not step while lower stage is not at 15
    load_n = 0; din = 8'h25; tick(); load_n = 1;
    tick(); check("R7 upper holds", q, 8'h26);

    // R2: clear beats load and count
    clr_n = 0; load_n = 0; din = 8'h77;
    tick(); check("R2 clear over load", q, 0);
    load_n = 1; tick(); check("R2 clear over count", q, 0);
    clr_n = 1;

    // R1: reset beats load
    load_n = 0; din = 8'h99; tick(); load_n = 1;
    rst = 1; clr_n = 1; load_n = 0; din = 8'h55;
    tick(); check("R1 reset over load", q, 0);
    rst = 0; load_n = 1;

    // R8: one final carry per 256 clocks
    pulses = 0; last_pulse = -1; gap_bad = 0;
    en_p = 1; en_t = 1;
    for (int i = 0; i < 768; i++) begin
      if (carry_out) begin
        if (last_pulse >= 0 && i - last_pulse != 256) gap_bad++;
        last_pulse = i;
        pulses++;
      end
      tick();
    end
    check("R8 pulse count", pulses, 3);
    check("R8 pulse spacing", gap_bad, 0);
    check("R8 final q", q, exp_q);

    finish_run();
  end
endmodule